// File: doc/BRIEF.md
# Stereo Serial Audio Clock and Frame Generator

This block drives the transmit side of an I2S link from a fixed 160 MHz base clock. The bit clock comes from two dividers in series: a prescaler, then a bit-clock divider. The register value of each divider is its divide ratio, with no offset. Each frame carries a left word and a right word of 16 bits, each sent MSB first. A pad setting lengthens every channel slot with zero bits placed after the word. With no padding, one word-select period is 32 bit clocks, so the sample rate is 160 MHz / (prescale × bitdiv × 32).

The block takes one stereo sample per frame over a valid/ready handshake. If no sample is offered when the frame starts, it sends the previous sample again. Changes to the divisors and to the pad setting are taken only when a frame starts, so the bit clock never glitches. Word select is low for the left slot and high for the right slot. It switches one bit clock before the MSB of the next word. Data and word select change on the falling edge of the bit clock.

Top module: `i2s_frame_gen`

## Requirements
- R1: While reset is held, bck_o, ws_o, sd_o and smp_ready_o are all low. Within five base clocks after reset is released, smp_ready_o pulses to start the first frame.
- R2: One bit period lasts P×D base clocks, where P is the effective prescale value and D is the effective bit divisor. In each bit period, bck_o is low for the first D−floor(D/2) prescaler periods and high for the rest.
- R3: Each divisor input is used directly as its divide ratio. A prescale value of 0 acts as 1. A bit divisor of 0 or 1 acts as 2.
- R4: A frame lasts 2×(16+N) bit periods, where N is the pad input (0 to 15). smp_ready_o is high for exactly one base clock, the last clock of each frame, and the following clock starts the new frame.
- R5: In bit periods 0 to 15 of a frame, sd_o carries the left word MSB first, followed by N zero bits. In bit periods 16+N onward, it carries the right word MSB first, followed by N zero bits.
- R6: ws_o is high in bit periods 15+N through 30+2N and low in all other bit periods. This places each switch one bit period ahead of the MSB of the next word.
- R7: After the first frame starts, sd_o and ws_o change only in a base clock in which bck_o falls.
- R8: A sample is captured when smp_valid_i and smp_ready_o are both high. If smp_valid_i is low in that cycle, the next frame sends the previously held sample again.
- R9: Changes to the divisor and pad inputs during a frame have no effect on that frame. The values present in the smp_ready_o cycle apply from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 160 MHz base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pre_div_i | input | 6 | Prescale divide ratio |
| bck_div_i | input | 6 | Bit-clock divide ratio |
| pad_bits_i | input | 4 | Zero bits appended to each channel slot |
| smp_left_i | input | 16 | Left channel sample |
| smp_right_i | input | 16 | Right channel sample |
| smp_valid_i | input | 1 | Sample offered |
| smp_ready_o | output | 1 | Sample taken in this cycle (frame start) |
| bck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (low = left) |
| sd_o | output | 1 | Serial data |

## Verification
The hardest case to reach from the ports is a divisor or pad change that arrives in the middle of a frame. The stimulus alters all three settings and the sample halfway through one captured frame. It then checks that every clock of that frame still matches the old settings. Repeating a held sample needs a frame that starts with valid low, which one table entry provides. The clamped divisor codes 0 and 1 and the largest prescaler value each get their own table entries.

// File: rtl/i2s_frame_pkg.sv
package i2s_frame_pkg;
  localparam int SAMPLE_W_DEF = 16;
  localparam int DIV_W_DEF    = 6;
  localparam int PAD_W_DEF    = 4;

  // bit position counter must hold twice the longest slot
  function automatic int pos_width(input int word_w, input int pad_w);
    return $clog2(2 * (word_w + (1 << pad_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/i2s_prescale.sv
module i2s_prescale #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == div_i - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_pcnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_i);
endmodule

// File: rtl/i2s_bitclk.sv
module i2s_bitclk #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, low_len;
  logic             bck_q, bck_d, cnt_en;

  assign low_len = div_i - (div_i >> 1);
  assign fall_o  = tick_i && (cnt_q == div_i - 1'b1);
  assign cnt_en  = restart_i | tick_i;
  assign bck_o   = bck_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (fall_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
    bck_d = restart_i ? 1'b0 : (cnt_d >= low_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      bck_q <= bck_d;
    end
  end

  assert_bcnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_i);
  assert_fall_from_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> bck_q);
  assert_bck_moves_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bck_q) |-> $past(tick_i));
endmodule

// File: rtl/i2s_framer.sv
module i2s_framer #(
  parameter int WORD_W = 16,
  parameter int PAD_W  = 4,
  parameter int POS_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              shift_i,
  input  logic [PAD_W-1:0]  pad_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              valid_i,
  output logic              ws_o,
  output logic              sd_o,
  output logic              frame_end_o
);
  logic [POS_W-1:0]  pos_q, pos_d, slot_cur, slot_nxt;
  logic [PAD_W-1:0]  pad_q, pad_d;
  logic [WORD_W-1:0] left_q, left_d, right_q, right_d, sh_q, sh_d;
  logic              ws_q, ws_d, upd_en;

  assign slot_cur    = POS_W'(WORD_W) + POS_W'(pad_q);
  assign frame_end_o = shift_i && (pos_q == (slot_cur << 1) - 1'b1);
  assign upd_en      = restart_i | shift_i;
  assign ws_o        = ws_q;
  assign sd_o        = sh_q[WORD_W-1];

  always_comb begin
    pos_d   = pos_q;
    pad_d   = pad_q;
    left_d  = left_q;
    right_d = right_q;
    sh_d    = sh_q;
    if (restart_i) begin
      pad_d = pad_i;
      pos_d = '0;
      if (valid_i) begin
        left_d  = left_i;
        right_d = right_i;
      end
    end else if (shift_i) begin
      pos_d = pos_q + 1'b1;
    end
    slot_nxt = POS_W'(WORD_W) + POS_W'(pad_d);
    if (restart_i)                sh_d = left_d;
    else if (pos_d == slot_nxt)   sh_d = right_q;
    else if (shift_i)             sh_d = {sh_q[WORD_W-2:0], 1'b0};
    ws_d = (pos_d >= slot_nxt - 1'b1) && (pos_d <= (slot_nxt << 1) - 2'd2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      pad_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
      sh_q    <= '0;
      ws_q    <= 1'b0;
    end else if (upd_en) begin
      pos_q   <= pos_d;
      pad_q   <= pad_d;
      left_q  <= left_d;
      right_q <= right_d;
      sh_q    <= sh_d;
      ws_q    <= ws_d;
    end
  end

  assert_pos_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < (slot_cur << 1));
  assert_ws_lead_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws_q) |-> (pos_q == slot_cur - 1'b1));
  assert_ws_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ws_q) |-> (pos_q == (slot_cur << 1) - 1'b1));
  assert_hold_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !valid_i) |=> $stable(left_q) && $stable(right_q));
endmodule

// File: rtl/i2s_frame_gen.sv
module i2s_frame_gen
  import i2s_frame_pkg::*;
#(
  parameter int WORD_W = SAMPLE_W_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int PAD_W  = PAD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  pre_div_i,
  input  logic [DIV_W-1:0]  bck_div_i,
  input  logic [PAD_W-1:0]  pad_bits_i,
  input  logic [WORD_W-1:0] smp_left_i,
  input  logic [WORD_W-1:0] smp_right_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  output logic              bck_o,
  output logic              ws_o,
  output logic              sd_o
);
  localparam int POS_W = pos_width(WORD_W, PAD_W);

  logic [1:0]       rs_q;
  logic             rst_n, boot_q, load, frame_end, pre_tick, bit_fall;
  logic [DIV_W-1:0] d1_q, d1_d, d2_q, d2_d, d1_eff, d2_eff;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  assign load        = (rst_n & ~boot_q) | frame_end;
  assign smp_ready_o = load;
  assign d1_eff      = (pre_div_i == '0) ? DIV_W'(1) : pre_div_i;
  assign d2_eff      = (bck_div_i < DIV_W'(2)) ? DIV_W'(2) : bck_div_i;

  always_comb begin
    d1_d = load ? d1_eff : d1_q;
    d2_d = load ? d2_eff : d2_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b0;
      d1_q   <= DIV_W'(1);
      d2_q   <= DIV_W'(2);
    end else begin
      boot_q <= 1'b1;
      if (load) begin
        d1_q <= d1_d;
        d2_q <= d2_d;
      end
    end
  end

  i2s_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .restart_i(load),
    .div_i(d1_q), .tick_o(pre_tick));

  i2s_bitclk #(.DIV_W(DIV_W)) u_bck (
    .clk_i(clk_i), .rst_ni(rst_n), .restart_i(load), .tick_i(pre_tick),
    .div_i(d2_q), .bck_o(bck_o), .fall_o(bit_fall));

  i2s_framer #(.WORD_W(WORD_W), .PAD_W(PAD_W), .POS_W(POS_W)) u_frm (
    .clk_i(clk_i), .rst_ni(rst_n), .restart_i(load), .shift_i(bit_fall),
    .pad_i(pad_bits_i), .left_i(smp_left_i), .right_i(smp_right_i),
    .valid_i(smp_valid_i), .ws_o(ws_o), .sd_o(sd_o), .frame_end_o(frame_end));

  assert_div_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (d1_q != '0) && (d2_q >= DIV_W'(2)));
  assert_sd_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!$stable(sd_o) && $past(boot_q)) |-> $fell(bck_o));
  assert_ws_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!$stable(ws_o) && $past(boot_q)) |-> $fell(bck_o));
  assert_ready_at_high_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (smp_ready_o && boot_q) |-> bck_o);
endmodule

// File: tb/i2s_frame_gen_tb.sv
module i2s_frame_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  pre_div, bck_div;
  logic [3:0]  pad;
  logic [15:0] sl, sr;
  logic        vld;
  logic        ready, bck, ws, sd;

  always #4 clk = ~clk;

  i2s_frame_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pre_div_i(pre_div), .bck_div_i(bck_div),
    .pad_bits_i(pad), .smp_left_i(sl), .smp_right_i(sr), .smp_valid_i(vld),
    .smp_ready_o(ready), .bck_o(bck), .ws_o(ws), .sd_o(sd));

  typedef struct packed {
    logic [5:0]  d1;
    logic [5:0]  d2;
    logic [3:0]  pad;
    logic        vld;
    logic        mid;
    logic [15:0] l;
    logic [15:0] r;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{6'd1,  6'd2, 4'd0,  1'b1, 1'b0, 16'hA5C3, 16'h3C5A},
    '{6'd3,  6'd4, 4'd0,  1'b1, 1'b0, 16'h8001, 16'h7FFE},
    '{6'd2,  6'd5, 4'd3,  1'b1, 1'b0, 16'h1234, 16'hFEDC},
    '{6'd0,  6'd0, 4'd1,  1'b1, 1'b0, 16'hC001, 16'h0F0F},
    '{6'd1,  6'd3, 4'd0,  1'b0, 1'b0, 16'h0000, 16'h0000},
    '{6'd2,  6'd2, 4'd15, 1'b1, 1'b1, 16'h5AA5, 16'hB44B},
    '{6'd1,  6'd1, 4'd0,  1'b1, 1'b0, 16'hF00D, 16'h0BAD},
    '{6'd63, 6'd2, 4'd0,  1'b1, 1'b0, 16'h9669, 16'h6996}
  };

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_l = '0, exp_r = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_sd(input int k, input int ls, input logic [15:0] l,
                                input logic [15:0] r);
    if (k < 16)      return l[15-k];
    if (k < ls)      return 1'b0;
    if (k < ls + 16) return r[15-(k-ls)];
    return 1'b0;
  endfunction

  task automatic run_vec(input int v);
    vec_t t = VT[v];
    int d1e, d2e, n, ls, f;
    int e_bck, e_sd, e_ws, e_rdy, e_r7;
    int a_bck, x_bck, a_sd, x_sd, a_ws, x_ws, a_rdy, x_rdy;
    logic p_bck, p_sd, p_ws;
    pre_div = t.d1; bck_div = t.d2; pad = t.pad; vld = t.vld;
    sl = t.l; sr = t.r;
    if (t.vld) begin exp_l = t.l; exp_r = t.r; end
    while (!ready) @(negedge clk);
    d1e = (t.d1 == 0) ? 1 : int'(t.d1);
    d2e = (t.d2 < 2) ? 2 : int'(t.d2);
    n = d1e * d2e; ls = 16 + int'(t.pad); f = 2 * ls * n;
    e_bck = 0; e_sd = 0; e_ws = 0; e_rdy = 0; e_r7 = 0;
    a_bck = 0; x_bck = 0; a_sd = 0; x_sd = 0; a_ws = 0; x_ws = 0; a_rdy = 0; x_rdy = 0;
    p_bck = bck; p_sd = sd; p_ws = ws;
    for (int c = 0; c < f; c++) begin
      int k, j;
      bit eb, es, ew, er;
      @(negedge clk);
      k  = c / n;
      j  = (c % n) / d1e;
      eb = (j >= d2e - d2e / 2);
      es = exp_sd(k, ls, exp_l, exp_r);
      ew = (k >= ls - 1) && (k <= 2 * ls - 2);
      er = (c == f - 1);
      if (bck !== eb && e_bck++ == 0) begin a_bck = bck; x_bck = eb; end
      if (sd  !== es && e_sd++  == 0) begin a_sd = sd;   x_sd = es;  end
      if (ws  !== ew && e_ws++  == 0) begin a_ws = ws;   x_ws = ew;  end
      if (ready !== er && e_rdy++ == 0) begin a_rdy = c; x_rdy = f - 1; end
      if (!(v == 0 && c == 0) && ((sd != p_sd) || (ws != p_ws)) && !(p_bck && !bck))
        e_r7++;
      p_bck = bck; p_sd = sd; p_ws = ws;
      if (t.mid && c == f / 2) begin
        pre_div = 6'd5; bck_div = 6'd7; pad = 4'd2;
        sl = 16'hFFFF; sr = 16'hFFFF; vld = 1'b1;
      end
    end
    // R2 R3: bit clock shape from divisors (clamped codes in entries 3 and 6)
    check(e_bck == 0, $sformatf("R2 R3 R9 bck vec%0d", v), a_bck, x_bck);
    // R5 R8 R9: serial data, held sample in entry 4, mid-frame change in entry 5
    check(e_sd == 0, $sformatf("R5 R8 R9 sd vec%0d", v), a_sd, x_sd);
    check(e_ws == 0, $sformatf("R6 R9 ws vec%0d", v), a_ws, x_ws);
    check(e_rdy == 0, $sformatf("R4 R9 ready cycle vec%0d", v), a_rdy, x_rdy);
    check(e_r7 == 0, $sformatf("R7 change off falling edge vec%0d", v), e_r7, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0;
    pre_div = VT[0].d1; bck_div = VT[0].d2; pad = VT[0].pad;
    sl = VT[0].l; sr = VT[0].r; vld = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    check({bck, ws, sd, ready} == 4'b0000, "R1 outputs in reset",
          int'({bck, ws, sd, ready}), 0);
    rst_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (ready) begin seen = 1'b1; break; end
    end
    check(seen, "R1 first ready after release", int'(seen), 1);
    for (int v = 0; v < NV; v++) run_vec(v);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule